// File: doc/BRIEF.md
# Fractional-Rate Serial Byte Receiver

This block receives asynchronous serial bytes (one start bit, eight data bits sent least significant bit first, an optional parity bit, one stop bit). Its bit timing does not come from an integer clock divider. A phase accumulator adds a 16-bit step to itself on every core clock, and each carry out of the accumulator is one oversampling tick. One tick occurs every sixteenth of a bit period. Software picks the step as `baud * 2^20 / f_core`, drops the fraction, and caps the result at 0xFFFF when it would otherwise reach 0x10000. The cap accepts a small rate error so that the block can run baud rates close to the core clock.

The serial line first passes through a two-flop synchroniser. A falling edge seen while idle starts a frame. The start bit is confirmed half a bit later, and every later bit is sampled once at its centre. Toggling on the line early in a bit therefore does not change the received value. Each finished frame produces a one-cycle strobe together with the byte, a parity-error flag and a frame-error flag. These outputs hold their values until the next frame completes. A low enable holds the receiver idle and clears the accumulator.

Top module: `nco_uart_rx`

## Requirements
- R1: On every enabled clock the 16-bit accumulator advances by `nco_step` modulo 2^16. A tick is produced in the cycle after each wrap-around, so ticks arrive at `nco_step/65536` per clock.
- R2: `rx_serial` passes through two synchronising flops before any edge detection or sampling. All frame timing is counted from the synchronised line.
- R3: The eight data bits are sampled at ticks 24, 40, …, 136, counted from the detected falling edge. The first sampled bit becomes bit 0 of `rx_data`.
- R4: A start is accepted only if the synchronised line is still low at the 8th tick after the falling edge. Otherwise the receiver returns to idle and produces no strobe.
- R5: With `parity_en`=1 a parity bit is sampled at tick 152. The stop bit then moves to tick 168. `rx_parity_err` is set when the parity bit differs from XOR(data) XOR `parity_odd`: `parity_odd`=1 asks for an odd count of ones over data plus parity, and 0 asks for an even count. With `parity_en`=0 there is no parity bit, the stop bit is at tick 152, and `rx_parity_err` is 0.
- R6: A low stop bit still produces the strobe, with `rx_frame_err`=1. The receiver then ignores the line until it has been seen high, and only after that can it detect a new falling edge.
- R7: `rx_valid` is high for exactly one cycle per completed frame. `rx_data`, `rx_parity_err` and `rx_frame_err` change only together with that strobe. All outputs are 0 after reset.
- R8: While `rx_enable` is 0 the receiver stays idle, the accumulator is held at 0, no tick occurs and `rx_valid` stays 0.
- R9: A step of 0xFFFF (one tick on nearly every clock) receives frames correctly.
- R10: Random toggling of the line in the first 10% of each bit period does not change the received byte or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enable; low holds idle and clears the accumulator |
| nco_step | input | 16 | Phase increment added each clock |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe per completed frame |
| rx_parity_err | output | 1 | Parity mismatch in the last frame |
| rx_frame_err | output | 1 | Stop bit was low in the last frame |

## Verification
The bench builds the block with its default widths: a 16-bit accumulator, 16 ticks per bit and eight data bits. At run time it drives three steps. Step 4096 gives exactly 16 clocks per tick. Step 5000 gives a fractional tick spacing, so the accumulator remainder drifts across bits. Step 0xFFFF is the capped value, where a tick lands on almost every clock and a bit lasts about 16 clocks. With glitches in the first tenth of each bit, the step values bring into reach an off-centre start edge and the smallest sampling margin. The bench also drives bad parity in both senses, a low stop bit followed by a long low line, a start pulse too short to survive the mid-bit check, and the enable dropping in the middle of a frame.

// File: rtl/nco_uart_rx_pkg.sv
package nco_uart_rx_pkg;

    localparam int ACC_W  = 16;
    localparam int OVS    = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              parity_err;
        logic              frame_err;
    } rx_result_t;

    // Parity bit that makes the total ones count match the selected sense.
    function automatic logic want_parity(logic [DATA_W-1:0] d, logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/nco_tick_gen.sv
module nco_tick_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] step,
    output logic         tick
);
    logic [W-1:0] acc_q;
    logic         tick_q;
    logic [W:0]   sum;

    assign sum  = {1'b0, acc_q} + {1'b0, step};
    assign tick = tick_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= sum[W-1:0];
            tick_q <= sum[W];
        end
    end

    // R1: a tick means the accumulator wrapped past 2^W on the previous add
    assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (tick_q && $past(en)) |->
        (({1'b0, acc_q} + (W+1)'(1 << W)) == ({1'b0, $past(acc_q)} + {1'b0, $past(step)})));

    // R8: no tick survives a disabled cycle
    assert_idle_notick_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick_q);

endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic line,
    output logic line_prev
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign line      = chain_q[STAGES-1];
    assign line_prev = prev_q;

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import nco_uart_rx_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int OV  = OVS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic          line,
    input  logic          line_prev,
    input  logic          parity_en,
    input  logic          parity_odd,
    output logic          valid,
    output rx_result_t    result
);
    localparam int CNT_W = $clog2(OV);
    localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OV/2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OV - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DW - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    shreg;
    logic             par_bit;
    logic             valid_q;
    rx_result_t       res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (line_prev && !line) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (tick) begin
                            if (cnt == CNT_MID) begin
                                cnt   <= '0;
                                idx   <= '0;
                                state <= line ? ST_IDLE : ST_DATA;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (tick) begin
                            if (cnt == CNT_LAST) begin
                                cnt   <= '0;
                                shreg <= {line, shreg[DW-1:1]};
                                if (idx == IDX_LAST) begin
                                    state <= parity_en ? ST_PARITY : ST_STOP;
                                end else begin
                                    idx <= idx + 1'b1;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_PARITY: begin
                        if (tick) begin
                            if (cnt == CNT_LAST) begin
                                cnt     <= '0;
                                par_bit <= line;
                                state   <= ST_STOP;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_STOP: begin
                        if (tick) begin
                            if (cnt == CNT_LAST) begin
                                cnt              <= '0;
                                valid_q          <= 1'b1;
                                res_q.data       <= shreg;
                                res_q.frame_err  <= !line;
                                res_q.parity_err <= parity_en &&
                                    (par_bit != want_parity(shreg, parity_odd));
                                state            <= line ? ST_IDLE : ST_HOLD;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (line) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign valid  = valid_q;
    assign result = res_q;

    // R7: strobe lasts a single cycle
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R7: result fields move only with the strobe
    assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(res_q));

    // R8: disabled receiver reports nothing
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !valid_q);

    // R5: no parity error when parity was off for the closing stop sample
    assert_parity_off_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !$past(parity_en)) |-> !res_q.parity_err);

    // R6: a frame error leaves the receiver waiting for a high line
    assert_ferr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_q && res_q.frame_err) |-> (state == ST_HOLD));

endmodule

// File: rtl/nco_uart_rx.sv
module nco_uart_rx
    import nco_uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic [ACC_W-1:0]  nco_step,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              rx_serial,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err,
    output logic              rx_frame_err
);
    logic       tick;
    logic       line;
    logic       line_prev;
    rx_result_t result;

    nco_tick_gen #(.W(ACC_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (rx_enable),
        .step (nco_step),
        .tick (tick)
    );

    rx_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .din       (rx_serial),
        .line      (line),
        .line_prev (line_prev)
    );

    rx_frame_fsm #(.DW(DATA_W), .OV(OVS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (rx_enable),
        .tick       (tick),
        .line       (line),
        .line_prev  (line_prev),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .valid      (rx_valid),
        .result     (result)
    );

    assign rx_data       = result.data;
    assign rx_parity_err = result.parity_err;
    assign rx_frame_err  = result.frame_err;

endmodule

// File: tb/nco_uart_rx_test.sv
module nco_uart_rx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_enable = 1'b0;
    logic [15:0] nco_step = 16'd4096;
    logic        parity_en = 1'b0;
    logic        parity_odd = 1'b0;
    logic        rx_serial = 1'b1;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_parity_err;
    logic        rx_frame_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int frames_seen = 0;
    int frames_sent = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nco_uart_rx uut (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .nco_step(nco_step),
        .parity_en(parity_en), .parity_odd(parity_odd), .rx_serial(rx_serial),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
    );

    // ---------------- behavioural reference (tick-count view) ----------------
    int       m_acc;
    bit       m_tick, m_s1, m_s2, m_prev;
    bit       busy, wait_high;
    int       m_t;
    bit [7:0] m_byte;
    bit       m_pbit;
    bit       m_valid, m_pe, m_fe;
    bit [7:0] m_data;

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_tick = 0; m_s1 = 1; m_s2 = 1; m_prev = 1;
            busy = 0; wait_high = 0; m_t = 0; m_byte = 0; m_pbit = 0;
            m_valid = 0; m_pe = 0; m_fe = 0; m_data = 0;
        end else begin
            bit ln, pv, tk;
            int stop_at;
            ln = m_s2; pv = m_prev; tk = m_tick;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = rx_serial;
            m_valid = 0;
            if (!rx_enable) begin
                busy = 0; wait_high = 0; m_acc = 0; m_tick = 0;
            end else begin
                int sum;
                sum = m_acc + int'(nco_step);
                m_tick = (sum >= 65536);
                m_acc = sum % 65536;
                if (!busy) begin
                    if (wait_high) begin
                        if (ln) wait_high = 0;
                    end else if (pv && !ln) begin
                        busy = 1; m_t = 0;
                    end
                end else if (tk) begin
                    m_t++;
                    stop_at = parity_en ? 168 : 152;
                    if (m_t == 8) begin
                        if (ln) busy = 0;
                    end else if (m_t >= 24 && m_t <= 136 && ((m_t - 24) % 16) == 0) begin
                        m_byte[(m_t - 24) / 16] = ln;
                    end else if (parity_en && m_t == 152) begin
                        m_pbit = ln;
                    end else if (m_t == stop_at) begin
                        m_valid = 1;
                        m_data = m_byte;
                        m_fe = !ln;
                        m_pe = parity_en && (m_pbit != ((^m_byte) ^ parity_odd));
                        busy = 0;
                        if (!ln) wait_high = 1;
                    end
                end
            end
        end
    end

    // ---------------- expected frames ----------------
    typedef struct { bit [7:0] d; bit pe; bit fe; } exp_t;
    exp_t expq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // per-clock comparison with the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(rx_valid == m_valid, "R7 (R2 latency)", "rx_valid", rx_valid, m_valid);
            check(rx_data == m_data, "R3", "rx_data", rx_data, m_data);
            check(rx_parity_err == m_pe, "R5", "rx_parity_err", rx_parity_err, m_pe);
            check(rx_frame_err == m_fe, "R6", "rx_frame_err", rx_frame_err, m_fe);
            if (rx_valid) begin
                frames_seen++;
                if (expq.size() == 0) begin
                    check(0, "R4", "unexpected frame", rx_data, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(rx_data == e.d, "R3 R10", "frame byte", rx_data, e.d);
                    check(rx_parity_err == e.pe, "R5", "frame parity flag", rx_parity_err, e.pe);
                    check(rx_frame_err == e.fe, "R6", "frame stop flag", rx_frame_err, e.fe);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive_bit(input bit v, input int bitc, input bit glitch);
        for (int c = 0; c < bitc; c++) begin
            @(negedge clk);
            if (glitch && c < bitc / 10) rx_serial = 1'($urandom % 2);
            else rx_serial = v;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_serial = 1'b1;
        end
    endtask

    task automatic send_frame(input bit [7:0] d, input int bitc, input bit pen,
                              input bit podd, input bit flip_par, input bit stop_v,
                              input bit glitch, input bit expect_it);
        bit pbit;
        @(negedge clk);
        parity_en = pen;
        parity_odd = podd;
        if (expect_it) begin
            exp_t e;
            e.d = d; e.pe = pen && flip_par; e.fe = !stop_v;
            expq.push_back(e);
            frames_sent++;
        end
        drive_bit(1'b0, bitc, glitch);
        for (int i = 0; i < 8; i++) drive_bit(d[i], bitc, glitch);
        if (pen) begin
            pbit = (^d) ^ podd ^ flip_par;
            drive_bit(pbit, bitc, glitch);
        end
        drive_bit(stop_v, bitc, glitch);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check(rx_valid == 0 && rx_data == 0 && !rx_parity_err && !rx_frame_err,
              "R7", "reset outputs", {rx_valid, rx_data, rx_parity_err, rx_frame_err}, 0);
        rx_enable = 1'b1;
        idle(100);

        // R1 R3: integer tick spacing, no parity, with and without glitches (R10)
        nco_step = 16'd4096;
        send_frame(8'hA5, 256, 0, 0, 0, 1, 0, 1); idle(300);
        send_frame(8'h3C, 256, 0, 0, 0, 1, 1, 1); idle(300);
        send_frame(8'h00, 256, 0, 0, 0, 1, 1, 1); idle(300);
        send_frame(8'hFF, 256, 0, 0, 0, 1, 0, 1); idle(300);

        // R5: even parity good then bad, odd parity good then bad
        send_frame(8'h5A, 256, 1, 0, 0, 1, 1, 1); idle(300);
        send_frame(8'h5B, 256, 1, 0, 1, 1, 0, 1); idle(300);
        send_frame(8'h81, 256, 1, 1, 0, 1, 0, 1); idle(300);
        send_frame(8'h7E, 256, 1, 1, 1, 1, 1, 1); idle(300);

        // R6: low stop bit, line stays low well past the frame, then recovers
        send_frame(8'h42, 256, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 700; i++) begin
            @(negedge clk); rx_serial = 1'b0;
        end
        idle(300);
        send_frame(8'h99, 256, 0, 0, 0, 1, 0, 1); idle(300);

        // R4: a short low pulse must not start a frame
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); rx_serial = 1'b0;
        end
        idle(3000);
        check(frames_seen == frames_sent, "R4", "frames after false start",
              frames_seen, frames_sent);
        send_frame(8'h11, 256, 0, 0, 0, 1, 0, 1); idle(300);

        // R1 R10: fractional step, bit near 209.7 clocks
        nco_step = 16'd5000;
        send_frame(8'hC3, 210, 1, 0, 0, 1, 1, 1); idle(300);
        send_frame(8'h2D, 210, 0, 0, 0, 1, 1, 1); idle(300);

        // R9: capped step 0xFFFF, about 16 clocks per bit
        nco_step = 16'hFFFF;
        send_frame(8'hE7, 16, 0, 0, 0, 1, 1, 1); idle(40);
        send_frame(8'h18, 16, 1, 1, 0, 1, 1, 1); idle(40);
        send_frame(8'h6B, 16, 1, 0, 1, 1, 0, 1); idle(40);

        // R8: disabled during a whole frame, then mid-frame
        nco_step = 16'd4096;
        @(negedge clk); rx_enable = 1'b0;
        send_frame(8'h55, 256, 0, 0, 0, 1, 0, 0); idle(300);
        check(rx_valid == 0 && frames_seen == frames_sent, "R8", "disabled frame ignored",
              frames_seen, frames_sent);
        @(negedge clk); rx_enable = 1'b1;
        idle(100);
        send_frame(8'hAA, 256, 0, 0, 0, 1, 0, 1); idle(300);
        @(negedge clk);
        parity_en = 0;
        drive_bit(1'b0, 256, 0);
        drive_bit(1'b1, 256, 0);
        drive_bit(1'b0, 256, 0);
        @(negedge clk); rx_enable = 1'b0;
        for (int i = 3; i < 8; i++) drive_bit(1'b1, 256, 0);
        drive_bit(1'b1, 256, 0);
        idle(300);
        @(negedge clk); rx_enable = 1'b1;
        idle(100);
        send_frame(8'h3E, 256, 0, 0, 0, 1, 0, 1); idle(500);

        check(expq.size() == 0, "R4 R8", "pending expected frames", expq.size(), 0);
        check(frames_seen == frames_sent, "R7", "frame count", frames_seen, frames_sent);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule